// File: doc/BRIEF.md
# Two-Wire Target Port for an Elapsed-Time Counter

This block connects an elapsed-time counter core to a two-wire (I2C) bus. It watches the bus lines, which arrive as raw samples on a fast system clock, and answers at one fixed 7-bit address. The master can read two 3-byte values. One is the live elapsed time, which is read-only. The other is the wake-up compare value, which the master can both read and write. SDA is driven as an open-drain output enable: a 1 pulls the line low.

In a write transaction, the first data byte after the address acts as a pointer. When its top bit is set, the next three bytes form a new wake-up value. That value goes to the core as one 24-bit word with a single-cycle strobe. When the top bit is clear, the write only selects the wake-up value for a following repeated-start read. A stop clears that selection, so a plain read returns the elapsed time. The core also reports whether its debounced reset is released. While that reset is held, the block refuses writes, and every read returns the elapsed time.

Top module: `tmr_i2c_target`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sda_oe` and `wake_wr` are 0.
- R2: An address byte whose upper seven bits are 0110010 is acknowledged by pulling SDA low in the ninth clock; any other address gets no acknowledge, and the block stays silent until the next start.
- R3: `sda_oe` only changes while SCL is low.
- R4: A write whose pointer byte has bit 7 = 1 and bit 0 = 1, followed by three data bytes sent most significant first, acknowledges every byte and pulses `wake_wr` for exactly one cycle, with `wake_wdata` equal to the three bytes joined; the pulse comes after the third data byte's acknowledge clock.
- R5: A write cut short by a stop or a repeated start before the third data byte produces no `wake_wr` pulse.
- R6: A read after a stop returns the elapsed time most significant byte first, taken from a copy captured when the read address is acknowledged; later changes of `time_now` do not affect the bytes sent.
- R7: Every byte read after the third is 0xFF.
- R8: A write whose pointer byte has bit 7 = 0 and bit 0 = 1, followed by a repeated start and a read, returns `wake_cur` when `core_run` is 1 at the read address, and `time_now` when `core_run` is 0.
- R9: A stop clears the pointer, so a read after a stop returns the elapsed time.
- R10: While `core_run` is 0, the address of a write is still acknowledged, the pointer byte and all later bytes are not, and no `wake_wr` pulse occurs.
- R11: A pointer byte with bit 0 = 0 is not acknowledged, and the write produces no `wake_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| time_now | input | 24 | Live elapsed-time counter value |
| wake_cur | input | 24 | Current wake-up compare value |
| core_run | input | 1 | Debounced counter reset state, 1 = released |
| wake_wr | output | 1 | One-cycle strobe that loads a new wake-up value |
| wake_wdata | output | 24 | New wake-up value, valid with `wake_wr` |

## Verification
A pin edge reaches the protocol logic after two synchronizer flops and one edge flop. So `sda_oe` responds on the third rising clock edge after an SCL fall. The `wake_wr` strobe comes the same three edges after the fall that ends the third data byte's acknowledge clock. The bench's bus master holds every SCL phase for 12 clocks and samples SDA at the middle of the high phase, well after every response has settled. It counts strobes on falling clock edges and checks that count only after the stop, so the exact strobe cycle never affects a check.

// File: rtl/tmr_i2c_pkg.sv
package tmr_i2c_pkg;
  // Fixed 7-bit bus address of the target
  localparam logic [6:0] TGT_ADDR = 7'b0110010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_e;
endpackage

// File: rtl/tmr_i2c_linesync.sv
module tmr_i2c_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // Bus conditions: SDA moves while SCL stays high
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tmr_i2c_rdsel.sv
module tmr_i2c_rdsel #(
  parameter int REG_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   capture,
  input  logic                   cap_wake,
  input  logic [8*REG_BYTES-1:0] time_val,
  input  logic [8*REG_BYTES-1:0] wake_val,
  input  logic [$clog2(REG_BYTES+1)-1:0] idx,
  output logic [7:0]             byte_o
);
  localparam int DW    = 8 * REG_BYTES;
  localparam int IDX_W = $clog2(REG_BYTES + 1);

  logic [DW-1:0] snap;
  logic [7:0]    slice [REG_BYTES];

  always_ff @(posedge clk) begin
    if (rst) snap <= '0;
    else if (capture) snap <= cap_wake ? wake_val : time_val;
  end

  // Byte 0 is the most significant one
  for (genvar g = 0; g < REG_BYTES; g++) begin : g_slice
    assign slice[g] = snap[DW-1-8*g -: 8];
  end

  always_comb begin
    byte_o = 8'hFF;
    for (int k = 0; k < REG_BYTES; k++) begin
      if (idx == IDX_W'(k)) byte_o = slice[k];
    end
  end
endmodule

// File: rtl/tmr_i2c_proto.sv
module tmr_i2c_proto
  import tmr_i2c_pkg::*;
#(
  parameter int REG_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sda_s,
  input  logic                   scl_rise,
  input  logic                   scl_fall,
  input  logic                   start_det,
  input  logic                   stop_det,
  input  logic                   core_run,
  input  logic [7:0]             rd_byte,
  output logic                   sda_oe,
  output logic                   wake_wr,
  output logic [8*REG_BYTES-1:0] wake_wdata,
  output logic                   snap_take,
  output logic                   snap_wake,
  output logic [$clog2(REG_BYTES+1)-1:0] rd_idx
);
  localparam int DW    = 8 * REG_BYTES;
  localparam int IDX_W = $clog2(REG_BYTES + 1);
  localparam int BN_W  = $clog2(REG_BYTES + 3);
  localparam logic [BN_W-1:0]  BN_PTR  = BN_W'(1);
  localparam logic [BN_W-1:0]  BN_LAST = BN_W'(REG_BYTES + 1);
  localparam logic [BN_W-1:0]  BN_MAX  = BN_W'(REG_BYTES + 2);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(REG_BYTES);

  phase_e          ph;
  logic [2:0]      bit_cnt;
  logic            got8;
  logic [7:0]      rx_sh;
  logic [6:0]      tx_sh;
  logic [BN_W-1:0] byte_no;
  logic            is_rd;
  logic            rd_wake;
  logic            wr_sel;
  logic            pend;
  logic            m_ack;
  logic [DW-1:0]   stage;
  logic            ack_ok;

  always_comb begin
    if (byte_no == '0)         ack_ok = (rx_sh[7:1] == TGT_ADDR);
    else if (byte_no == BN_PTR) ack_ok = core_run & rx_sh[0];
    else                       ack_ok = core_run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      bit_cnt    <= '0;
      got8       <= 1'b0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      byte_no    <= '0;
      is_rd      <= 1'b0;
      rd_wake    <= 1'b0;
      wr_sel     <= 1'b0;
      pend       <= 1'b0;
      m_ack      <= 1'b0;
      stage      <= '0;
      sda_oe     <= 1'b0;
      wake_wr    <= 1'b0;
      wake_wdata <= '0;
      snap_take  <= 1'b0;
      snap_wake  <= 1'b0;
      rd_idx     <= '0;
    end else begin
      wake_wr   <= 1'b0;
      snap_take <= 1'b0;
      if (start_det) begin
        ph      <= PH_RX;
        bit_cnt <= '0;
        got8    <= 1'b0;
        byte_no <= '0;
        is_rd   <= 1'b0;
        wr_sel  <= 1'b0;
        pend    <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        ph      <= PH_IDLE;
        got8    <= 1'b0;
        pend    <= 1'b0;
        rd_wake <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (ph)
          PH_RX: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) got8 <= 1'b1;
            end else if (scl_fall && got8) begin
              got8    <= 1'b0;
              bit_cnt <= '0;
              if (ack_ok) begin
                sda_oe <= 1'b1;
                ph     <= PH_RX_ACK;
                if (byte_no == '0) begin
                  is_rd <= rx_sh[0];
                  if (rx_sh[0]) begin
                    snap_take <= 1'b1;
                    snap_wake <= rd_wake & core_run;
                    rd_idx    <= '0;
                  end
                end else if (byte_no == BN_PTR) begin
                  rd_wake <= ~rx_sh[7];
                  wr_sel  <= rx_sh[7];
                end else if (byte_no <= BN_LAST) begin
                  stage <= {stage[DW-9:0], rx_sh};
                  if (byte_no == BN_LAST && wr_sel) pend <= 1'b1;
                end
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_rd) begin
                ph     <= PH_TX;
                tx_sh  <= rd_byte[6:0];
                sda_oe <= ~rd_byte[7];
              end else begin
                ph     <= PH_RX;
                sda_oe <= 1'b0;
                if (byte_no != BN_MAX) byte_no <= byte_no + BN_W'(1);
                if (pend) begin
                  wake_wr    <= 1'b1;
                  wake_wdata <= stage;
                  pend       <= 1'b0;
                end
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                ph     <= PH_TX_ACK;
                sda_oe <= 1'b0;
                if (rd_idx != IDX_END) rd_idx <= rd_idx + IDX_W'(1);
              end else begin
                sda_oe  <= ~tx_sh[6];
                tx_sh   <= {tx_sh[5:0], 1'b1};
                bit_cnt <= bit_cnt + 3'd1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            else if (scl_fall) begin
              if (m_ack) begin
                ph      <= PH_TX;
                tx_sh   <= rd_byte[6:0];
                sda_oe  <= ~rd_byte[7];
                bit_cnt <= '0;
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_i2c_target.sv
module tmr_i2c_target #(
  parameter int REG_BYTES   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic [8*REG_BYTES-1:0] time_now,
  input  logic [8*REG_BYTES-1:0] wake_cur,
  input  logic                   core_run,
  output logic                   wake_wr,
  output logic [8*REG_BYTES-1:0] wake_wdata
);
  localparam int IDX_W = $clog2(REG_BYTES + 1);

  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             snap_take;
  logic             snap_wake;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;

  tmr_i2c_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tmr_i2c_rdsel #(.REG_BYTES(REG_BYTES)) u_rdsel (
    .clk      (clk),
    .rst      (rst),
    .capture  (snap_take),
    .cap_wake (snap_wake),
    .time_val (time_now),
    .wake_val (wake_cur),
    .idx      (rd_idx),
    .byte_o   (rd_byte)
  );

  tmr_i2c_proto #(.REG_BYTES(REG_BYTES)) u_proto (
    .clk        (clk),
    .rst        (rst),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .core_run   (core_run),
    .rd_byte    (rd_byte),
    .sda_oe     (sda_oe),
    .wake_wr    (wake_wr),
    .wake_wdata (wake_wdata),
    .snap_take  (snap_take),
    .snap_wake  (snap_wake),
    .rd_idx     (rd_idx)
  );
endmodule

// File: rtl/tmr_i2c_target_chk.sv
module tmr_i2c_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe,
  input logic wake_wr,
  input logic core_run
);
  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!sda_oe && !wake_wr));

  // R3
  a_r3_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R4
  a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wake_wr |=> !wake_wr);

  // R10
  a_r10_no_strobe_held: assert property (@(posedge clk) disable iff (rst)
    wake_wr |-> core_run);
endmodule

bind tmr_i2c_target tmr_i2c_target_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .wake_wr  (wake_wr),
  .core_run (core_run)
);

// File: tb/tmr_i2c_target_bench.sv
module tmr_i2c_target_bench;
  localparam int Q = 12;
  localparam logic [7:0] AW = 8'h64;
  localparam logic [7:0] AR = 8'h65;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_oe;
  logic        sda_bus;
  logic [23:0] time_now = 24'h0;
  logic [23:0] wake_cur = 24'h0;
  logic        core_run = 1'b1;
  logic        wake_wr;
  logic [23:0] wake_wdata;

  int n_chk = 0;
  int n_bad = 0;
  int strobes = 0;
  logic [23:0] last_wdata = '0;
  int r3_viol = 0;
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  tmr_i2c_target u_tmr_i2c_target (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .time_now(time_now), .wake_cur(wake_cur), .core_run(core_run),
    .wake_wr(wake_wr), .wake_wdata(wake_wdata)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wake_wr) begin
        strobes++;
        last_wdata = wake_wdata;
      end
      if (sda_oe != oe_prev && m_scl) r3_viol++;
    end
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitc(Q);
    m_scl = 1'b1; waitc(Q);
    m_sda = 1'b0; waitc(Q);
    m_scl = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitc(Q);
    m_scl = 1'b1; waitc(Q);
    m_sda = 1'b1; waitc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; waitc(Q);
      m_scl = 1'b1; waitc(Q);
      m_scl = 1'b0; waitc(Q);
    end
    m_sda = 1'b1; waitc(Q);
    m_scl = 1'b1; waitc(Q/2);
    acked = (sda_bus == 1'b0);
    waitc(Q/2);
    m_scl = 1'b0; waitc(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(Q);
      m_scl = 1'b1; waitc(Q/2);
      b[i] = sda_bus;
      waitc(Q/2);
      m_scl = 1'b0;
    end
    waitc(Q);
    m_sda = nack; waitc(Q);
    m_scl = 1'b1; waitc(Q);
    m_scl = 1'b0;
    m_sda = 1'b1; waitc(Q);
  endtask

  task automatic read3(input string req, input logic [23:0] exp);
    logic [7:0] b;
    recv_byte(1'b0, b); chk(req, b, exp[23:16]);
    recv_byte(1'b0, b); chk(req, b, exp[15:8]);
    recv_byte(1'b1, b); chk(req, b, exp[7:0]);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 wake_wr", wake_wr, 0);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start(); send_byte(8'h66, a); chk("R2 foreign address", a, 0);
    send_byte(8'h00, a); chk("R2 silent after mismatch", a, 0);
    bus_stop();
  endtask

  task automatic t_write_full();
    logic a; int s0 = strobes;
    core_run = 1'b1;
    bus_start(); send_byte(AW, a); chk("R2 own address", a, 1);
    send_byte(8'h81, a); chk("R4 pointer ack", a, 1);
    send_byte(8'h12, a); chk("R4 data ack", a, 1);
    send_byte(8'h34, a); chk("R4 data ack", a, 1);
    send_byte(8'h56, a); chk("R4 data ack", a, 1);
    bus_stop();
    chk("R4 strobe count", strobes - s0, 1);
    chk("R4 strobe data", last_wdata, 24'h123456);
  endtask

  task automatic t_write_short();
    logic a; int s0 = strobes;
    bus_start(); send_byte(AW, a); send_byte(8'h81, a);
    send_byte(8'hAA, a); send_byte(8'hBB, a);
    bus_stop();
    chk("R5 stop after two bytes", strobes - s0, 0);
    bus_start(); send_byte(AW, a); send_byte(8'hFF, a); send_byte(8'hCC, a);
    bus_start(); send_byte(AW, a);
    bus_stop();
    chk("R5 restart after one byte", strobes - s0, 0);
  endtask

  task automatic t_read_time();
    logic a; logic [7:0] b;
    core_run = 1'b1;
    time_now = 24'hA1B2C3;
    bus_start(); send_byte(AR, a); chk("R2 read address", a, 1);
    time_now = 24'h0F0F0F;
    recv_byte(1'b0, b); chk("R6 byte0", b, 8'hA1);
    recv_byte(1'b0, b); chk("R6 byte1", b, 8'hB2);
    recv_byte(1'b0, b); chk("R6 byte2", b, 8'hC3);
    recv_byte(1'b0, b); chk("R7 past end", b, 8'hFF);
    recv_byte(1'b1, b); chk("R7 past end", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_wake_read(input logic run_at_read);
    logic a;
    core_run = 1'b1;
    time_now = 24'h13579B;
    wake_cur = 24'h5A6B7C;
    bus_start(); send_byte(AW, a); send_byte(8'h01, a); chk("R8 dummy pointer ack", a, 1);
    core_run = run_at_read;
    bus_start(); send_byte(AR, a);
    if (run_at_read) read3("R8 wake bytes", 24'h5A6B7C);
    else read3("R8 held returns time", 24'h13579B);
    bus_stop();
    core_run = 1'b1;
  endtask

  task automatic t_stop_clears();
    logic a;
    time_now = 24'h2468AC;
    wake_cur = 24'hDEAD01;
    bus_start(); send_byte(AW, a); send_byte(8'h01, a);
    bus_stop();
    bus_start(); send_byte(AR, a);
    read3("R9 time after stop", 24'h2468AC);
    bus_stop();
  endtask

  task automatic t_held_write();
    logic a; int s0 = strobes;
    core_run = 1'b0;
    bus_start(); send_byte(AW, a); chk("R10 address ack", a, 1);
    send_byte(8'h81, a); chk("R10 pointer refused", a, 0);
    send_byte(8'h11, a); chk("R10 data refused", a, 0);
    bus_stop();
    chk("R10 no strobe", strobes - s0, 0);
    core_run = 1'b1;
  endtask

  task automatic t_bad_ptr();
    logic a; int s0 = strobes;
    bus_start(); send_byte(AW, a); send_byte(8'h80, a); chk("R11 bit0 clear refused", a, 0);
    send_byte(8'h22, a); send_byte(8'h33, a); send_byte(8'h44, a);
    bus_stop();
    chk("R11 no strobe", strobes - s0, 0);
  endtask

  initial begin
    waitc(6);
    rst = 1'b0;
    waitc(2);
    t_reset();
    t_wrong_addr();
    t_write_full();
    t_write_short();
    t_read_time();
    t_wake_read(1'b1);
    t_wake_read(1'b0);
    t_stop_clears();
    t_held_write();
    t_bad_ptr();
    chk("R3 sda_oe moved while SCL high", r3_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule